// File: doc/BRIEF.md
# Integer Register File with Write Bypass

This block holds the architectural integer registers of a small RISC-V core: 32 entries of 32 bits each. It offers two read ports and one write port. Each read port returns data for its source address in the same cycle, with no clock in the path. The write port commits data to the array on the rising clock edge.

Entry 0 is the hardwired zero register. It reads as zero on both ports, and writes aimed at it are dropped. When a read port selects the entry that is being written in the current cycle, it returns the incoming write data rather than the older stored word. A core can therefore write back and read operands in the same cycle without a separate forwarding path for the file.

The array has no reset input, so no reset network reaches the storage. Its contents start at zero, which keeps early reads deterministic.

Top module: `int_regfile`

## Requirements
- R1: Before any write has been committed, every address reads as zero on both read ports.
- R2: When write enable is high and the destination address is nonzero, the write data is stored at the rising clock edge. Later reads of that address return it.
- R3: With write enable low, no entry changes at the clock edge.
- R4: Each read port's data follows its source address within the same cycle, with no clock edge in between.
- R5: A source address of 0 returns zero on either port, whatever else happens in that cycle.
- R6: A write with destination address 0 changes nothing. Address 0 still reads zero during that cycle and in every later cycle.
- R7: When write enable is high, the destination address is nonzero, and a source address equals the destination address, that read port returns the incoming write data in the same cycle.
- R8: When write enable is low and a source address equals the destination address, the read port returns the stored value and not the write data.
- R9: When both source addresses are equal, both ports return identical data. This holds under the bypass and zero-register rules as well.
- R10: The two read ports are independent. Changing one port's source address does not change the other port's data.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock; writes commit on the rising edge |
| wr_en_i | input | 1 | Write enable |
| wr_addr_i | input | 5 | Destination register address |
| wr_data_i | input | 32 | Data to write |
| rs_a_addr_i | input | 5 | Source address of read port A |
| rs_b_addr_i | input | 5 | Source address of read port B |
| rs_a_data_o | output | 32 | Read data of port A |
| rs_b_data_o | output | 32 | Read data of port B |

## Verification
The embedded assertions check the following on every clock:
- the zero register reads zero on both ports;
- a port that matches an enabled nonzero write returns that write's data;
- two ports with equal addresses return equal data;
- an entry not targeted by an enabled write holds its value across the edge;
- a committed write is read back on the next cycle.

Some behaviours need the bench's scenarios instead:
- the all-zero starting contents;
- read data following an address change mid-cycle without a clock;
- the absence of bypass when write enable is low;
- the independence of the two ports.

The bench also drives long randomised sequences with frequent address collisions against its own model.

// File: rtl/rf_pkg.sv
`timescale 1ns/1ps
package rf_pkg;

  localparam int unsigned RF_XLEN  = 32;
  localparam int unsigned RF_NREGS = 32;
  localparam int unsigned RF_AW    = $clog2(RF_NREGS);

  typedef logic [RF_AW-1:0]   rf_addr_t;
  typedef logic [RF_XLEN-1:0] rf_word_t;

  // True when the address names the hardwired zero register.
  function automatic logic f_is_zero_reg(input rf_addr_t a);
    return (a == '0);
  endfunction

  // A write is effective only if enabled and not aimed at the zero register.
  function automatic logic f_write_live(input logic we, input rf_addr_t wa);
    return we && !f_is_zero_reg(wa);
  endfunction

  // Bypass hit: a live write targets the address being read.
  function automatic logic f_bypass_hit(input logic we, input rf_addr_t wa,
                                        input rf_addr_t ra);
    return f_write_live(we, wa) && (wa == ra);
  endfunction

  // Final read value: zero register dominates, then bypass, then storage.
  function automatic rf_word_t f_read_pick(input logic zero_sel, input logic hit,
                                           input rf_word_t wd, input rf_word_t stored);
    rf_word_t v;
    if (zero_sel)  v = '0;
    else if (hit)  v = wd;
    else           v = stored;
    return v;
  endfunction

endpackage

// File: rtl/rf_storage.sv
`timescale 1ns/1ps
module rf_storage #(
  parameter int unsigned XLEN  = 32,
  parameter int unsigned NREGS = 32,
  parameter int unsigned NRD   = 2,
  localparam int unsigned AW   = $clog2(NREGS)
) (
  input  logic            clk_i,
  input  logic            wr_en_i,
  input  logic [AW-1:0]   wr_addr_i,
  input  logic [XLEN-1:0] wr_data_i,
  input  logic [AW-1:0]   rd_addr_i [NRD],
  output logic [XLEN-1:0] rd_data_o [NRD]
);

  logic [XLEN-1:0] mem_q [NREGS];
  logic            wr_commit;

  // Deterministic starting contents, no reset network.
  initial begin
    for (int i = 0; i < NREGS; i++) mem_q[i] = '0;
  end

  assign wr_commit = wr_en_i && (wr_addr_i != '0);

  always_ff @(posedge clk_i) begin
    if (wr_commit) mem_q[wr_addr_i] <= wr_data_i;
  end

  for (genvar p = 0; p < NRD; p++) begin : g_rd
    assign rd_data_o[p] = mem_q[rd_addr_i[p]];
  end

  // Assertion enable: becomes 1 after the first clock edge.
  logic chk_live;
  always_ff @(posedge clk_i) chk_live <= 1'b1;

  for (genvar e = 0; e < NREGS; e++) begin : g_hold
    // R3
    entry_hold_chk: assert property (@(posedge clk_i) disable iff (chk_live !== 1'b1)
      !(wr_en_i && (wr_addr_i == AW'(e))) |=> $stable(mem_q[e]))
      else $error("entry %0d changed without a write", e);
  end

endmodule

// File: rtl/rf_read_port.sv
`timescale 1ns/1ps
module rf_read_port
  import rf_pkg::*;
(
  input  logic     clk_i,
  input  rf_addr_t rd_addr_i,
  input  logic     wr_en_i,
  input  rf_addr_t wr_addr_i,
  input  rf_word_t wr_data_i,
  input  rf_word_t stored_i,
  output rf_word_t rd_data_o
);

  logic zero_sel;
  logic byp_hit;

  assign zero_sel  = f_is_zero_reg(rd_addr_i);
  assign byp_hit   = f_bypass_hit(wr_en_i, wr_addr_i, rd_addr_i);
  assign rd_data_o = f_read_pick(zero_sel, byp_hit, wr_data_i, stored_i);

  logic chk_live;
  always_ff @(posedge clk_i) chk_live <= 1'b1;

  // R5
  zero_read_chk: assert property (@(posedge clk_i) disable iff (chk_live !== 1'b1)
    (rd_addr_i == '0) |-> (rd_data_o == '0))
    else $error("zero register read nonzero");

  // R7
  bypass_sel_chk: assert property (@(posedge clk_i) disable iff (chk_live !== 1'b1)
    byp_hit |-> !zero_sel)
    else $error("bypass selected for zero register");

endmodule

// File: rtl/int_regfile.sv
`timescale 1ns/1ps
module int_regfile
  import rf_pkg::*;
#(
  parameter int unsigned NRD = 2
) (
  input  logic                clk_i,
  input  logic                wr_en_i,
  input  logic [RF_AW-1:0]    wr_addr_i,
  input  logic [RF_XLEN-1:0]  wr_data_i,
  input  logic [RF_AW-1:0]    rs_a_addr_i,
  input  logic [RF_AW-1:0]    rs_b_addr_i,
  output logic [RF_XLEN-1:0]  rs_a_data_o,
  output logic [RF_XLEN-1:0]  rs_b_data_o
);

  rf_addr_t rd_addr_v   [NRD];
  rf_word_t stored_v    [NRD];
  rf_word_t rd_data_v   [NRD];

  assign rd_addr_v[0] = rs_a_addr_i;
  assign rd_addr_v[1] = rs_b_addr_i;

  rf_storage #(
    .XLEN (RF_XLEN),
    .NREGS(RF_NREGS),
    .NRD  (NRD)
  ) store_i (
    .clk_i    (clk_i),
    .wr_en_i  (wr_en_i),
    .wr_addr_i(wr_addr_i),
    .wr_data_i(wr_data_i),
    .rd_addr_i(rd_addr_v),
    .rd_data_o(stored_v)
  );

  for (genvar p = 0; p < NRD; p++) begin : g_port
    rf_read_port port_i (
      .clk_i    (clk_i),
      .rd_addr_i(rd_addr_v[p]),
      .wr_en_i  (wr_en_i),
      .wr_addr_i(wr_addr_i),
      .wr_data_i(wr_data_i),
      .stored_i (stored_v[p]),
      .rd_data_o(rd_data_v[p])
    );
  end

  assign rs_a_data_o = rd_data_v[0];
  assign rs_b_data_o = rd_data_v[1];

  logic chk_live;
  always_ff @(posedge clk_i) chk_live <= 1'b1;

  // R7
  bypass_a_chk: assert property (@(posedge clk_i) disable iff (chk_live !== 1'b1)
    (wr_en_i && wr_addr_i != '0 && rs_a_addr_i == wr_addr_i) |-> (rs_a_data_o == wr_data_i))
    else $error("port A bypass mismatch");

  // R7
  bypass_b_chk: assert property (@(posedge clk_i) disable iff (chk_live !== 1'b1)
    (wr_en_i && wr_addr_i != '0 && rs_b_addr_i == wr_addr_i) |-> (rs_b_data_o == wr_data_i))
    else $error("port B bypass mismatch");

  // R9
  same_addr_chk: assert property (@(posedge clk_i) disable iff (chk_live !== 1'b1)
    (rs_a_addr_i == rs_b_addr_i) |-> (rs_a_data_o == rs_b_data_o))
    else $error("ports disagree on equal addresses");

  // R6
  zero_write_chk: assert property (@(posedge clk_i) disable iff (chk_live !== 1'b1)
    (wr_en_i && wr_addr_i == '0 && rs_a_addr_i == '0) |-> (rs_a_data_o == '0))
    else $error("write to zero register visible");

  // R2
  write_lands_chk: assert property (@(posedge clk_i) disable iff (chk_live !== 1'b1)
    (wr_en_i && wr_addr_i != '0) |=>
      (!(rs_a_addr_i == $past(wr_addr_i) && !(wr_en_i && wr_addr_i == rs_a_addr_i))
       || (rs_a_data_o == $past(wr_data_i))))
    else $error("committed write not read back");

endmodule

// File: tb/int_regfile_tb_top.sv
`timescale 1ns/1ps
module int_regfile_tb_top;

  logic        clk = 1'b0;
  logic        wr_en = 1'b0;
  logic [4:0]  wr_addr = '0;
  logic [31:0] wr_data = '0;
  logic [4:0]  ra = '0;
  logic [4:0]  rb = '0;
  logic [31:0] da;
  logic [31:0] db;

  int checks = 0;
  int fails  = 0;
  logic [31:0] model [32];

  always #2 clk = ~clk;

  int_regfile dut_i (
    .clk_i      (clk),
    .wr_en_i    (wr_en),
    .wr_addr_i  (wr_addr),
    .wr_data_i  (wr_data),
    .rs_a_addr_i(ra),
    .rs_b_addr_i(rb),
    .rs_a_data_o(da),
    .rs_b_data_o(db)
  );

  task automatic check(string tag, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  // Model read: zero register, then pending write, then stored model.
  function automatic logic [31:0] expect_rd(int a);
    if (a == 0) return 32'h0;
    if (wr_en && int'(wr_addr) == a) return wr_data;
    return model[a];
  endfunction

  task automatic cycle(bit we, int wa, logic [31:0] wd, int a, int b, string tag);
    @(negedge clk);
    wr_en = we; wr_addr = 5'(wa); wr_data = wd; ra = 5'(a); rb = 5'(b);
    #1;
    check({tag, " portA"}, da, expect_rd(a));
    check({tag, " portB"}, db, expect_rd(b));
    @(posedge clk);
    if (we && wa != 0) model[wa] = wd;
  endtask

  task automatic peek(int a, int b, string tag);
    ra = 5'(a); rb = 5'(b);
    #0.3;
    check({tag, " portA"}, da, expect_rd(a));
    check({tag, " portB"}, db, expect_rd(b));
  endtask

  initial begin
    #(200000 * 4);
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    for (int i = 0; i < 32; i++) model[i] = '0;

    // R1: all entries start at zero
    for (int i = 0; i < 32; i++) cycle(0, 0, 32'h0, i, 31 - i, "R1 initial zero");

    // R2: writes land and read back later
    for (int i = 1; i < 32; i++) cycle(1, i, 32'hA500_0000 + i, 0, 0, "R2 write");
    for (int i = 1; i < 32; i++) cycle(0, 0, 32'h0, i, i, "R2 readback");

    // R3: write enable low leaves contents unchanged
    cycle(0, 7, 32'hDEAD_BEEF, 0, 0, "R3 disabled write");
    cycle(0, 0, 32'h0, 7, 7, "R3 entry unchanged");

    // R8: matching address with enable low returns stored word
    cycle(0, 9, 32'h1234_5678, 9, 9, "R8 no bypass when disabled");

    // R7: same-cycle bypass on both ports
    cycle(1, 12, 32'hCAFE_0012, 12, 3, "R7 bypass A");
    cycle(1, 13, 32'hCAFE_0013, 4, 13, "R7 bypass B");

    // R6: writes to the zero register are dropped
    cycle(1, 0, 32'hFFFF_FFFF, 0, 0, "R6 write x0 same cycle");
    cycle(0, 0, 32'h0, 0, 0, "R6 x0 after write");

    // R5: address 0 reads zero during an unrelated write
    cycle(1, 5, 32'h5555_5555, 0, 5, "R5 zero during write");

    // R9: both ports on the same address, with and without bypass
    cycle(1, 20, 32'h0BAD_F00D, 20, 20, "R9 same addr bypass");
    cycle(0, 0, 32'h0, 21, 21, "R9 same addr stored");

    // R4 and R10: mid-cycle address changes with no clock edge
    @(negedge clk);
    wr_en = 1'b0;
    peek(3, 4, "R4 follow 1");
    peek(6, 4, "R10 B unchanged");
    peek(6, 8, "R4 follow 2");
    peek(0, 8, "R4 to zero");
    @(posedge clk);

    // Randomised sequences with frequent collisions
    for (int n = 0; n < 3000; n++) begin
      bit we = 1'($urandom_range(0, 1));
      int wa = ($urandom_range(0, 1) == 1) ? int'($urandom_range(0, 5)) : int'($urandom_range(0, 31));
      int a  = ($urandom_range(0, 1) == 1) ? wa : int'($urandom_range(0, 31));
      int b  = ($urandom_range(0, 2) == 0) ? a : int'($urandom_range(0, 31));
      cycle(we, wa, $urandom(), a, b, "R7 R9 random");
    end

    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

endmodule